// File: doc/BRIEF.md
# Diagnostic Port Lock and Erase Controller

This block decides when a diagnostic service port may be opened. It watches a pad-detect input that reports whether a diagnostic pad is physically attached, and a lock request from the system. If the pad is missing when the chip comes out of hard reset, the port is shut for good: a latched lockout holds it closed until the next hard reset. The same lockout is latched when the port is held locked and the pad is then taken away. A warm reset returns the sequencer to idle but leaves the lockout in place.

Every time the port is about to open, the block first asks an external engine to wipe all volatile memory. It holds that request until the engine reports completion, and only then raises the port enable. If the pad goes away during a wipe, the wipe still runs to the end but the port stays shut. A configuration input can waive the wipe for the first opening after hard reset when the port was already active before that reset. The raw pad-detect signal passes through a two-stage synchronizer and a 16-cycle stability filter before the block acts on it. Once the port is open, the protocol logic behind it has full access to firmware images. That access is outside this block.

Top module: `dpl_ctrl`

## Requirements
- R1: During and right after hard reset, port_en and erase_req are 0 and status is 0 (idle).
- R2: A change on pad_det takes effect only after it has held for 16 consecutive synchronized cycles. Low pulses of 8 cycles on an attached pad leave an open port open.
- R3: With the pad attached, no lock and no lockout, the block raises erase_req and reports status 1 (erasing). port_en stays 0 while erase_req is high.
- R4: An erase_done pulse while erasing opens the port on the next clock edge (port_en 1, status 2, erase_req 0). erase_done at any other time has no effect.
- R5: If the filtered pad is absent on the first decision after hard reset, the block latches lockout and reports status 3. A later pad insertion does not open the port.
- R6: A high lock_req closes an open port on the next edge (status 0). When lock_req is released with the pad still attached, the port reopens only through a fresh erase.
- R7: lock_req held high while the filtered pad is absent latches lockout (status 3). Releasing lock_req and reattaching the pad does not reopen the port, and erase_done is ignored.
- R8: When the pad is removed with no lock request, the port closes (status 0) without lockout. Reattaching the pad starts a new erase and then opens the port.
- R9: If the pad is removed during an erase, erase_req stays high until erase_done. The port then stays closed (status 0).
- R10: warm_rst returns the sequencer to idle for one cycle but does not clear lockout. A locked block shows status 3 again, and an unlocked one with the pad attached starts a new erase.
- R11: When skip_cfg and prior_active are both 1, the first opening after hard reset goes straight to status 2 with no erase_req. Later openings, and any opening with prior_active 0, erase first.
- R12: Only the hard reset rst clears the lockout. After rst with the pad attached, the erase and open sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high; clears everything including lockout |
| warm_rst | input | 1 | Warm reset, synchronous, active high; idles the sequencer, keeps lockout |
| pad_det | input | 1 | Raw, asynchronous diagnostic pad presence |
| lock_req | input | 1 | Level lock request; high keeps the port closed |
| erase_done | input | 1 | Pulse from the memory wipe engine when the erase is complete |
| skip_cfg | input | 1 | Configuration: allow skipping the first erase when prior_active is 1 |
| prior_active | input | 1 | The port was active at the time of the last hard reset |
| port_en | output | 1 | Diagnostic port enable |
| erase_req | output | 1 | Volatile memory erase request, held until erase_done |
| status | output | 2 | 0 idle, 1 erasing, 2 open, 3 locked out |

## Verification
On every cycle the assertions check the following. The port and the erase request are never high together. The port never opens except right after erase_done or on the permitted skip path. An erase request never drops before completion or warm reset. The lockout and the locked state are sticky across warm resets. The filtered pad only changes after a full stability window. Whether the lockout is latched at the right moment, the startup decision, glitch rejection on real pad pulses, and the skip path taken only on the first opening need the bench's scenarios. Those scenarios cover pad removal during an erase, lock followed by removal, and hard versus warm reset.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ERASE  = 2'd1,
        ST_OPEN   = 2'd2,
        ST_LOCKED = 2'd3
    } dpl_state_e;

    typedef struct packed {
        logic valid;
        logic present;
    } pad_view_t;

    function automatic logic may_open(input pad_view_t pv, input logic lock, input logic lockout);
        return pv.valid && pv.present && !lock && !lockout;
    endfunction

    function automatic logic lock_event(input pad_view_t pv, input logic first_seen,
                                        input logic lock);
        return pv.valid && !pv.present && (!first_seen || lock);
    endfunction

endpackage

// File: rtl/dpl_pad_filter.sv
module dpl_pad_filter
    import dpl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pad_raw,
    output pad_view_t pv
);
    localparam int CW = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(DEB_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cand_q;
    logic [CW-1:0]          cnt_q;
    pad_view_t              pv_q;
    logic                   s_now;

    assign s_now = sync_q[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pad_raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pad_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= 1'b0;
            cnt_q  <= '0;
            pv_q   <= '0;
        end else if (s_now != cand_q) begin
            cand_q <= s_now;
            cnt_q  <= '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pv_q.present <= cand_q;
            pv_q.valid   <= 1'b1;
        end
    end

    assign pv = pv_q;

    // R2
    filt_window_chk: assert property (@(posedge clk) disable iff (rst)
        (pv_q.present != $past(pv_q.present)) |-> ($past(cnt_q) == CNT_TOP));

endmodule

// File: rtl/dpl_lockout.sv
module dpl_lockout
    import dpl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pad_view_t pv,
    input  logic      lock_req,
    output logic      lockout
);
    logic seen_q;
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            seen_q <= seen_q | pv.valid;
            if (lock_event(pv, seen_q, lock_req))
                lock_q <= 1'b1;
        end
    end

    assign lockout = lock_q;

    // R10
    lockout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

endmodule

// File: rtl/dpl_seq.sv
module dpl_seq
    import dpl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       warm_rst,
    input  pad_view_t  pv,
    input  logic       lock_req,
    input  logic       lockout,
    input  logic       erase_done,
    input  logic       skip_cfg,
    input  logic       prior_active,
    output dpl_state_e state
);
    dpl_state_e st_q, st_d;
    logic       opened_q;
    logic       go;
    logic       skip_ok;

    assign go      = may_open(pv, lock_req, lockout);
    assign skip_ok = skip_cfg && prior_active && !opened_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (lockout)  st_d = ST_LOCKED;
                else if (go)  st_d = skip_ok ? ST_OPEN : ST_ERASE;
            end
            ST_ERASE: begin
                if (erase_done) begin
                    if (lockout)  st_d = ST_LOCKED;
                    else if (go)  st_d = ST_OPEN;
                    else          st_d = ST_IDLE;
                end
            end
            ST_OPEN: begin
                if (lockout)  st_d = ST_LOCKED;
                else if (!go) st_d = ST_IDLE;
            end
            default: st_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            opened_q <= 1'b0;
        end else begin
            st_q <= warm_rst ? ST_IDLE : st_d;
            if (!warm_rst && st_q == ST_IDLE && (st_d == ST_ERASE || st_d == ST_OPEN))
                opened_q <= 1'b1;
        end
    end

    assign state = st_q;

    // R4
    open_after_erase_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OPEN && $past(st_q) != ST_OPEN) |->
            ($past(erase_done) || $past(skip_ok)));

    // R9
    erase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ERASE && !erase_done && !warm_rst) |=> (st_q == ST_ERASE));

    // R5
    locked_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCKED && !warm_rst) |=> (st_q == ST_LOCKED));

endmodule

// File: rtl/dpl_ctrl.sv
module dpl_ctrl
    import dpl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       warm_rst,
    input  logic       pad_det,
    input  logic       lock_req,
    input  logic       erase_done,
    input  logic       skip_cfg,
    input  logic       prior_active,
    output logic       port_en,
    output logic       erase_req,
    output logic [1:0] status
);
    pad_view_t  pv;
    logic       lockout;
    dpl_state_e state;

    dpl_pad_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYC(DEB_CYC)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .pad_raw (pad_det),
        .pv      (pv)
    );

    dpl_lockout u_lock (
        .clk      (clk),
        .rst      (rst),
        .pv       (pv),
        .lock_req (lock_req),
        .lockout  (lockout)
    );

    dpl_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .warm_rst     (warm_rst),
        .pv           (pv),
        .lock_req     (lock_req),
        .lockout      (lockout),
        .erase_done   (erase_done),
        .skip_cfg     (skip_cfg),
        .prior_active (prior_active),
        .state        (state)
    );

    assign port_en   = (state == ST_OPEN);
    assign erase_req = (state == ST_ERASE);
    assign status    = state;

    // R3
    en_erase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(port_en && erase_req));

    // R7
    no_open_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
        lockout |-> !port_en);

endmodule

// File: tb/dpl_ctrl_tb.sv
module dpl_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       warm_rst = 1'b0;
    logic       pad_det = 1'b0;
    logic       lock_req = 1'b0;
    logic       erase_done = 1'b0;
    logic       skip_cfg = 1'b0;
    logic       prior_active = 1'b0;
    logic       port_en;
    logic       erase_req;
    logic [1:0] status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam int SETTLE = 30;

    always #4 clk = ~clk;

    dpl_ctrl u_dut (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .pad_det(pad_det),
        .lock_req(lock_req), .erase_done(erase_done), .skip_cfg(skip_cfg),
        .prior_active(prior_active), .port_en(port_en), .erase_req(erase_req),
        .status(status)
    );

    function automatic int exp_en(input int st);
        return (st == 2) ? 1 : 0;
    endfunction

    function automatic int exp_er(input int st);
        return (st == 1) ? 1 : 0;
    endfunction

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input int st);
        chk(req, int'(status), st);
        chk(req, int'(port_en), exp_en(st));
        chk(req, int'(erase_req), exp_er(st));
    endtask

    task automatic hard_reset(input logic pad);
        pad_det = pad;
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic pulse_done();
        erase_done = 1'b1;
        tick(1);
        erase_done = 1'b0;
    endtask

    initial begin
        int seen;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);

        hard_reset(1'b1);
        chk_state("R1", 0);
        tick(SETTLE);
        chk_state("R3", 1);
        pulse_done();
        chk_state("R4", 2);
        pulse_done();
        chk_state("R4 done ignored when open", 2);

        for (int k = 0; k < 12; k++) begin
            int lat;
            lock_req = 1'b1;
            tick(1);
            chk_state("R6 lock closes", 0);
            tick(1 + ($urandom % 5));
            lock_req = 1'b0;
            tick(1);
            chk_state("R6 reopen erases", 1);
            lat = 1 + ($urandom % 12);
            for (int j = 0; j < lat; j++) begin
                tick(1);
                chk("R3 waits for done", int'(port_en), 0);
            end
            pulse_done();
            chk_state("R6 reopened", 2);
        end

        lock_req = 1'b1;
        tick(1);
        pulse_done();
        chk_state("R4 done ignored when idle", 0);
        lock_req = 1'b0;
        tick(1);
        pulse_done();
        chk_state("R4", 2);

        pad_det = 1'b0;
        tick(SETTLE);
        chk_state("R8 removal closes", 0);
        pad_det = 1'b1;
        tick(SETTLE);
        chk_state("R8 reinsertion erases", 1);
        pulse_done();
        chk_state("R8 reopened", 2);

        lock_req = 1'b1;
        tick(2);
        lock_req = 1'b0;
        tick(1);
        chk_state("R9 erase started", 1);
        pad_det = 1'b0;
        tick(SETTLE);
        chk_state("R9 erase held", 1);
        pulse_done();
        chk_state("R9 stays closed", 0);
        pad_det = 1'b1;
        tick(SETTLE);
        pulse_done();
        chk_state("R9 recovered", 2);

        warm_rst = 1'b1;
        tick(1);
        warm_rst = 1'b0;
        chk_state("R10 warm idles", 0);
        tick(1);
        chk_state("R10 warm re-erases", 1);
        pulse_done();

        for (int k = 0; k < 5; k++) begin
            pad_det = 1'b0;
            tick(8);
            pad_det = 1'b1;
            tick(8 + ($urandom % 6));
        end
        tick(SETTLE);
        chk_state("R2 glitches rejected", 2);

        lock_req = 1'b1;
        pad_det = 1'b0;
        tick(SETTLE);
        chk_state("R7 lockout", 3);
        lock_req = 1'b0;
        pad_det = 1'b1;
        tick(SETTLE + 10);
        pulse_done();
        chk_state("R7 stays locked", 3);
        warm_rst = 1'b1;
        tick(1);
        warm_rst = 1'b0;
        tick(2);
        chk_state("R10 warm keeps lockout", 3);

        hard_reset(1'b1);
        tick(SETTLE);
        chk_state("R12 hard reset clears lockout", 1);
        pulse_done();
        chk_state("R12", 2);

        hard_reset(1'b0);
        tick(SETTLE);
        chk_state("R5 startup lockout", 3);
        pad_det = 1'b1;
        tick(SETTLE + 10);
        chk_state("R5 insertion ignored", 3);

        skip_cfg = 1'b1;
        prior_active = 1'b1;
        hard_reset(1'b1);
        seen = 0;
        for (int j = 0; j < SETTLE; j++) begin
            tick(1);
            if (erase_req) seen = 1;
        end
        chk("R11 no erase on skip", seen, 0);
        chk_state("R11 direct open", 2);
        pad_det = 1'b0;
        tick(SETTLE);
        pad_det = 1'b1;
        tick(SETTLE);
        chk_state("R11 later opening erases", 1);
        pulse_done();

        prior_active = 1'b0;
        hard_reset(1'b1);
        tick(SETTLE);
        chk_state("R11 prior inactive erases", 1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule